// File: doc/BRIEF.md
# Big-endian load/store lane aligner

This block sits between a load/store unit and a 32-bit data bus. For every memory request it forms the effective address from a base register value and a signed 16-bit displacement. For a store it steers the source data into the lanes that the address selects and raises the matching byte enables. For a load it records which lanes were addressed and how wide the access was. When the bus later returns the read word, it extracts the addressed byte or halfword and extends it to 32 bits for the register file.

Lane numbering is big-endian: the lowest address of a word is its most significant byte. Accesses that are not aligned to their natural size are flagged, and they drive no byte enables. All outputs come from registers. A two-flop synchronizer releases the asynchronous active-low reset on a clock edge.

Top module: `la_lane_align`

## Requirements
- R1: `bus_addr` equals `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32.
- R2: A byte store (`req_size`=0) at address offset k (bits 1:0) puts `req_wdata[7:0]` into bits 31-8k down to 24-8k of `bus_wdata`, with zeros elsewhere. It drives `bus_be` = 4'b1000 >> k, where bit 3 of `bus_be` is the lane of bits 31:24.
- R3: A halfword store (`req_size`=1) at offset 0 puts `req_wdata[15:0]` into bits 31:16 with `bus_be`=4'b1100. At offset 2 it puts the same data into bits 15:0 with `bus_be`=4'b0011. The other bits are zero.
- R4: A word store (`req_size`=2 or 3) at offset 0 passes `req_wdata` unchanged with `bus_be`=4'b1111.
- R5: A halfword access with address bit 0 set, or a word access with address bits 1:0 nonzero, sets `misalign` and forces `bus_be` to 0. A byte access never sets `misalign`.
- R6: A byte load returns the addressed byte (offset 0 = `rsp_rdata[31:24]`, offset 3 = `rsp_rdata[7:0]`). With `req_unsigned`=0 the byte is sign-extended; with `req_unsigned`=1 it is zero-extended.
- R7: A halfword load returns `rsp_rdata[31:16]` for offset 0 and `rsp_rdata[15:0]` for offset 2. It is sign-extended or zero-extended according to `req_unsigned`.
- R8: A word load returns all 32 bits of `rsp_rdata` unchanged, whatever `req_unsigned` is.
- R9: `bus_vld` is high exactly in the cycle after each cycle with `req_vld` high. `ld_vld` is high exactly in the cycle after each cycle with `rsp_vld` high. Both are one-cycle pulses per input cycle.
- R10: A response is decoded with the lane, size and signedness of the most recent aligned load request. Stores and misaligned loads do not change that context.
- R11: While reset is held, and until it has been released through the synchronizer, `bus_vld`, `ld_vld`, `misalign` and `bus_be` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_unsigned | input | 1 | Load extension: 1 zero, 0 sign |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| bus_vld | output | 1 | Registered request to the bus |
| bus_addr | output | 32 | Effective address |
| bus_we | output | 1 | Write strobe (store) |
| bus_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| bus_wdata | output | 32 | Lane-placed store data |
| misalign | output | 1 | Access not naturally aligned |
| rsp_vld | input | 1 | Read data from the bus is valid |
| rsp_rdata | input | 32 | Read word from the bus |
| ld_vld | output | 1 | Extended load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
Every result of this block is one register stage behind its cause. The address, enables, store data and misalign flag are due in the cycle after `req_vld` is sampled, and the load result is due in the cycle after `rsp_vld` is sampled. The bench drives inputs on the falling edge, holds them across one rising edge, and reads outputs at the next falling edge, which is exactly one register stage later. It then reads the valid strobes once more a cycle later to confirm that they are single pulses. Load context is exercised by putting stores and a misaligned load between a load request and its response.

// File: rtl/la_pkg.sv
package la_pkg;
  localparam int unsigned LA_DATA_W = 32;
  localparam int unsigned LA_LANES  = LA_DATA_W / 8;
  localparam int unsigned LA_OFS_W  = $clog2(LA_LANES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } la_size_e;

  typedef struct packed {
    logic [LA_OFS_W-1:0] ofs;
    la_size_e            size;
    logic                uns;
  } la_ctx_t;

  function automatic logic is_word(input la_size_e s);
    return s[1];
  endfunction
endpackage

// File: rtl/la_addr_gen.sv
module la_addr_gen
  import la_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  la_size_e          size,
  output logic [ADDR_W-1:0] addr,
  output logic              mis
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    addr    = base + off_ext;
    if (is_word(size))       mis = |addr[1:0];
    else if (size == SZ_HALF) mis = addr[0];
    else                     mis = 1'b0;
  end
endmodule

// File: rtl/la_store_lane.sv
module la_store_lane
  import la_pkg::*;
(
  input  logic [LA_OFS_W-1:0]  ofs,
  input  la_size_e             size,
  input  logic                 mis,
  input  logic [LA_DATA_W-1:0] src,
  output logic [LA_LANES-1:0]  be,
  output logic [LA_DATA_W-1:0] wdata
);
  // lane i (0 = lowest address) occupies the most significant byte first
  for (genvar i = 0; i < LA_LANES; i++) begin : g_lane
    localparam logic [LA_OFS_W-1:0] LI = LA_OFS_W'(i);
    localparam int unsigned         HI = LA_DATA_W - 1 - 8 * i;
    logic       sel;
    logic [7:0] byte_v;

    always_comb begin
      if (is_word(size)) begin
        sel    = 1'b1;
        byte_v = src[HI -: 8];
      end else if (size == SZ_HALF) begin
        sel    = (ofs[1] == LI[1]);
        byte_v = LI[0] ? src[7:0] : src[15:8];
      end else begin
        sel    = (ofs == LI);
        byte_v = src[7:0];
      end
    end

    assign wdata[HI -: 8]            = sel ? byte_v : 8'h00;
    assign be[LA_LANES - 1 - i]      = sel & ~mis;
  end
endmodule

// File: rtl/la_load_extract.sv
module la_load_extract
  import la_pkg::*;
(
  input  la_ctx_t              ctx,
  input  logic [LA_DATA_W-1:0] rdata,
  output logic [LA_DATA_W-1:0] result
);
  logic [7:0]  b_sel;
  logic [15:0] h_sel;

  always_comb begin
    case (ctx.ofs)
      2'd0:    b_sel = rdata[31:24];
      2'd1:    b_sel = rdata[23:16];
      2'd2:    b_sel = rdata[15:8];
      default: b_sel = rdata[7:0];
    endcase
    h_sel = ctx.ofs[1] ? rdata[15:0] : rdata[31:16];

    if (is_word(ctx.size))
      result = rdata;
    else if (ctx.size == SZ_HALF)
      result = {{16{h_sel[15] & ~ctx.uns}}, h_sel};
    else
      result = {{24{b_sel[7] & ~ctx.uns}}, b_sel};
  end
endmodule

// File: rtl/la_lane_align.sv
module la_lane_align
  import la_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_vld,
  input  logic        req_store,
  input  logic [1:0]  req_size,
  input  logic        req_unsigned,
  input  logic [31:0] req_base,
  input  logic [15:0] req_offset,
  input  logic [31:0] req_wdata,
  output logic        bus_vld,
  output logic [31:0] bus_addr,
  output logic        bus_we,
  output logic [3:0]  bus_be,
  output logic [31:0] bus_wdata,
  output logic        misalign,
  input  logic        rsp_vld,
  input  logic [31:0] rsp_rdata,
  output logic        ld_vld,
  output logic [31:0] ld_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // combinational request path
  la_size_e          size_c;
  logic [31:0]       addr_c;
  logic              mis_c;
  logic [3:0]        be_c;
  logic [31:0]       wdata_c;
  la_ctx_t           ctx_q, ctx_d;
  logic              ctx_en;
  logic [31:0]       ext_c;

  assign size_c = la_size_e'(req_size);

  la_addr_gen #(.ADDR_W(32), .OFF_W(16)) u_addr (
    .base   (req_base),
    .offset (req_offset),
    .size   (size_c),
    .addr   (addr_c),
    .mis    (mis_c)
  );

  la_store_lane u_store (
    .ofs   (addr_c[1:0]),
    .size  (size_c),
    .mis   (mis_c),
    .src   (req_wdata),
    .be    (be_c),
    .wdata (wdata_c)
  );

  la_load_extract u_load (
    .ctx    (ctx_q),
    .rdata  (rsp_rdata),
    .result (ext_c)
  );

  // next state
  logic        bus_vld_d, ld_vld_d;
  always_comb begin
    bus_vld_d  = req_vld;
    ld_vld_d   = rsp_vld;
    ctx_en     = req_vld & ~req_store & ~mis_c;
    ctx_d.ofs  = addr_c[1:0];
    ctx_d.size = size_c;
    ctx_d.uns  = req_unsigned;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bus_vld <= 1'b0;
      ld_vld  <= 1'b0;
    end else begin
      bus_vld <= bus_vld_d;
      ld_vld  <= ld_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      bus_addr  <= '0;
      bus_we    <= 1'b0;
      bus_be    <= '0;
      bus_wdata <= '0;
      misalign  <= 1'b0;
    end else if (req_vld) begin
      bus_addr  <= addr_c;
      bus_we    <= req_store;
      bus_be    <= be_c;
      bus_wdata <= wdata_c;
      misalign  <= mis_c;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ctx_q <= '{ofs: '0, size: SZ_WORD, uns: 1'b0};
    else if (ctx_en) ctx_q <= ctx_d;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)       ld_data <= '0;
    else if (rsp_vld) ld_data <= ext_c;
  end
endmodule

// File: rtl/la_lane_align_chk.sv
module la_lane_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_vld,
  input logic [1:0]  req_size,
  input logic [31:0] req_base,
  input logic [15:0] req_offset,
  input logic        bus_vld,
  input logic [31:0] bus_addr,
  input logic [3:0]  bus_be,
  input logic        misalign,
  input logic        rsp_vld,
  input logic        ld_vld
);
  AST_ADDR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> bus_addr == $past(req_base) + {{16{$past(req_offset[15])}}, $past(req_offset)}); // R1
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_size == 2'd0) |=> ($countones(bus_be) == 1 && !misalign)); // R2
  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_size[1]) |=> (misalign || bus_be == 4'hF)); // R4
  AST_MIS_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> bus_be == 4'h0); // R5
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> bus_vld); // R9
  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !bus_vld); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |=> ld_vld); // R9
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |=> !ld_vld); // R9
endmodule

bind la_lane_align la_lane_align_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .req_vld    (req_vld),
  .req_size   (req_size),
  .req_base   (req_base),
  .req_offset (req_offset),
  .bus_vld    (bus_vld),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .misalign   (misalign),
  .rsp_vld    (rsp_vld),
  .ld_vld     (ld_vld)
);

// File: tb/la_lane_align_test.sv
module la_lane_align_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_store, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_wdata;
  logic [15:0] req_offset;
  logic        bus_vld, bus_we, misalign;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic        rsp_vld, ld_vld;
  logic [31:0] rsp_rdata, ld_data;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  la_lane_align uut (
    .clk(clk), .rst_n(rst_n),
    .req_vld(req_vld), .req_store(req_store), .req_size(req_size),
    .req_unsigned(req_unsigned), .req_base(req_base), .req_offset(req_offset),
    .req_wdata(req_wdata),
    .bus_vld(bus_vld), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .misalign(misalign),
    .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata), .ld_vld(ld_vld), .ld_data(ld_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request for one cycle; outputs readable on return
  task automatic issue(input logic st, input logic [1:0] sz, input logic uns,
                       input logic [31:0] base, input logic [15:0] ofs,
                       input logic [31:0] wd);
    @(negedge clk);
    req_vld = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
    req_base = base; req_offset = ofs; req_wdata = wd;
    @(negedge clk);
    req_vld = 1'b0; req_store = 1'b0; req_base = 32'h0; req_offset = 16'h0;
  endtask

  task automatic respond(input logic [31:0] rd);
    @(negedge clk);
    rsp_vld = 1'b1; rsp_rdata = rd;
    @(negedge clk);
    rsp_vld = 1'b0; rsp_rdata = 32'h0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    req_vld = 0; req_store = 0; req_size = 0; req_unsigned = 0;
    req_base = 0; req_offset = 0; req_wdata = 0; rsp_vld = 0; rsp_rdata = 0;
    repeat (3) @(negedge clk);
    chk("R11 bus_vld", {31'b0, bus_vld}, 32'h0);
    chk("R11 ld_vld", {31'b0, ld_vld}, 32'h0);
    chk("R11 misalign", {31'b0, misalign}, 32'h0);
    chk("R11 bus_be", {28'b0, bus_be}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 bus_vld after release", {31'b0, bus_vld}, 32'h0);
  endtask

  task automatic t_addr;
    issue(1'b0, 2'd2, 1'b0, 32'h0000_1000, 16'hFFFC, 32'h0);
    chk("R1 negative offset", bus_addr, 32'h0000_0FFC);
    issue(1'b0, 2'd0, 1'b0, 32'hFFFF_FFFE, 16'h0004, 32'h0);
    chk("R1 wrap", bus_addr, 32'h0000_0002);
    issue(1'b0, 2'd0, 1'b0, 32'h1234_0000, 16'h7FFF, 32'h0);
    chk("R1 max positive", bus_addr, 32'h1234_7FFF);
  endtask

  task automatic t_store_byte;
    for (int k = 0; k < 4; k++) begin
      issue(1'b1, 2'd0, 1'b0, 32'h0000_2000, 16'(k), 32'hAABB_CC5A);
      chk($sformatf("R2 be ofs%0d", k), {28'b0, bus_be}, {28'b0, 4'b1000 >> k});
      chk($sformatf("R2 wdata ofs%0d", k), bus_wdata, 32'h0000_005A << (8 * (3 - k)));
      chk("R2 we", {31'b0, bus_we}, 32'h1);
    end
  endtask

  task automatic t_store_half;
    issue(1'b1, 2'd1, 1'b0, 32'h0000_3000, 16'h0000, 32'h1111_BEEF);
    chk("R3 be ofs0", {28'b0, bus_be}, 32'hC);
    chk("R3 wdata ofs0", bus_wdata, 32'hBEEF_0000);
    issue(1'b1, 2'd1, 1'b0, 32'h0000_3000, 16'h0002, 32'h1111_BEEF);
    chk("R3 be ofs2", {28'b0, bus_be}, 32'h3);
    chk("R3 wdata ofs2", bus_wdata, 32'h0000_BEEF);
  endtask

  task automatic t_store_word;
    issue(1'b1, 2'd2, 1'b0, 32'h0000_4000, 16'h0000, 32'hDEAD_BEEF);
    chk("R4 be", {28'b0, bus_be}, 32'hF);
    chk("R4 wdata", bus_wdata, 32'hDEAD_BEEF);
    issue(1'b1, 2'd3, 1'b0, 32'h0000_4004, 16'h0000, 32'h0123_4567);
    chk("R4 size3 be", {28'b0, bus_be}, 32'hF);
    chk("R4 size3 wdata", bus_wdata, 32'h0123_4567);
  endtask

  task automatic t_misalign;
    issue(1'b1, 2'd1, 1'b0, 32'h0000_0101, 16'h0000, 32'hFFFF);
    chk("R5 half ofs1 flag", {31'b0, misalign}, 32'h1);
    chk("R5 half ofs1 be", {28'b0, bus_be}, 32'h0);
    issue(1'b1, 2'd1, 1'b0, 32'h0000_0100, 16'h0003, 32'hFFFF);
    chk("R5 half ofs3 flag", {31'b0, misalign}, 32'h1);
    issue(1'b1, 2'd2, 1'b0, 32'h0000_0102, 16'h0000, 32'h1);
    chk("R5 word ofs2 flag", {31'b0, misalign}, 32'h1);
    chk("R5 word ofs2 be", {28'b0, bus_be}, 32'h0);
    issue(1'b1, 2'd0, 1'b0, 32'h0000_0103, 16'h0000, 32'h1);
    chk("R5 byte ofs3 no flag", {31'b0, misalign}, 32'h0);
    issue(1'b1, 2'd2, 1'b0, 32'h0000_0103, 16'hFFFD, 32'h1);
    chk("R5 word aligned no flag", {31'b0, misalign}, 32'h0);
  endtask

  task automatic t_load_byte;
    for (int k = 0; k < 4; k++) begin
      issue(1'b0, 2'd0, 1'b0, 32'h0000_5000, 16'(k), 32'h0);
      respond(32'h8172_E304);
      chk($sformatf("R6 signed ofs%0d", k), ld_data,
          32'($signed((32'h8172_E304 >> (8 * (3 - k))) << 24) >>> 24));
      issue(1'b0, 2'd0, 1'b1, 32'h0000_5000, 16'(k), 32'h0);
      respond(32'h8172_E304);
      chk($sformatf("R6 unsigned ofs%0d", k), ld_data,
          (32'h8172_E304 >> (8 * (3 - k))) & 32'hFF);
    end
  endtask

  task automatic t_load_half;
    issue(1'b0, 2'd1, 1'b0, 32'h0000_6000, 16'h0000, 32'h0);
    respond(32'h9ABC_1234);
    chk("R7 signed ofs0", ld_data, 32'hFFFF_9ABC);
    issue(1'b0, 2'd1, 1'b1, 32'h0000_6000, 16'h0000, 32'h0);
    respond(32'h9ABC_1234);
    chk("R7 unsigned ofs0", ld_data, 32'h0000_9ABC);
    issue(1'b0, 2'd1, 1'b0, 32'h0000_6000, 16'h0002, 32'h0);
    respond(32'h9ABC_F234);
    chk("R7 signed ofs2", ld_data, 32'hFFFF_F234);
    issue(1'b0, 2'd1, 1'b0, 32'h0000_6000, 16'h0002, 32'h0);
    respond(32'h9ABC_1234);
    chk("R7 signed ofs2 positive", ld_data, 32'h0000_1234);
  endtask

  task automatic t_load_word;
    issue(1'b0, 2'd2, 1'b0, 32'h0000_7000, 16'h0000, 32'h0);
    respond(32'hF00D_CAFE);
    chk("R8 word", ld_data, 32'hF00D_CAFE);
    issue(1'b0, 2'd2, 1'b1, 32'h0000_7000, 16'h0000, 32'h0);
    respond(32'h8000_0001);
    chk("R8 word unsigned flag ignored", ld_data, 32'h8000_0001);
  endtask

  task automatic t_ctx;
    issue(1'b0, 2'd0, 1'b1, 32'h0000_8000, 16'h0001, 32'h0);
    issue(1'b1, 2'd2, 1'b0, 32'h0000_8000, 16'h0000, 32'hFFFF_FFFF);
    issue(1'b0, 2'd1, 1'b0, 32'h0000_8001, 16'h0000, 32'h0);
    respond(32'h11F2_3344);
    chk("R10 context kept", ld_data, 32'h0000_00F2);
  endtask

  task automatic t_timing;
    @(negedge clk);
    req_vld = 1'b1; req_store = 1'b1; req_size = 2'd0; req_base = 32'h10; req_offset = 16'h0;
    chk("R9 bus_vld not early", {31'b0, bus_vld}, 32'h0);
    @(negedge clk);
    req_vld = 1'b0;
    chk("R9 bus_vld due", {31'b0, bus_vld}, 32'h1);
    @(negedge clk);
    chk("R9 bus_vld pulse", {31'b0, bus_vld}, 32'h0);
    rsp_vld = 1'b1; rsp_rdata = 32'h0;
    chk("R9 ld_vld not early", {31'b0, ld_vld}, 32'h0);
    @(negedge clk);
    rsp_vld = 1'b0;
    chk("R9 ld_vld due", {31'b0, ld_vld}, 32'h1);
    @(negedge clk);
    chk("R9 ld_vld pulse", {31'b0, ld_vld}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_addr();
    t_store_byte();
    t_store_half();
    t_store_word();
    t_misalign();
    t_load_byte();
    t_load_half();
    t_load_word();
    t_ctx();
    t_timing();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule